// File: doc/BRIEF.md
# Fractional SPI Serial Clock Generator

This block derives the serial clock of an SPI master from a much faster reference clock. An 11-bit phase accumulator advances by a programmable step on every enabled reference cycle. The step is a fraction of 2048, so the serial clock runs at the reference rate times the step divided by 2048. The top bit of the accumulator is the raw clock waveform. The polarity control inverts it to give the pin level. Each time that bit changes, the block raises a one-cycle strobe tagged as a rising or a falling pin edge, and the shift engine uses these strobes to launch and sample data.

The shift engine raises `run` for the length of a transfer. When `run` drops, the clock finishes any active half period before it parks at the idle level. An optional restart mode clears the accumulator when a transfer begins, so the first edge always comes at the same distance from the start. A global enable must be set before the block produces any clock activity at all.

Software chooses the step as ceil(2048 / ceil(f_ref / f_target)). Steps larger than 1024 are limited to 1024, so the serial clock never runs faster than half the reference rate.

Top module: `spi_frac_clkgen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the accumulator is zero, `sck` equals `cpol` and both strobes are low.
- R2: With `gate_en` low, the accumulator clears at the next clock edge. From the following cycle on, no strobe fires and `sck` sits at the idle level `cpol`.
- R3: With `gate_en` and `run` held high and a step W between 1 and 1024, every 2048 enabled cycles that start from a zero accumulator produce exactly W rising and W falling strobes. The serial rate is therefore f_ref·W/2048.
- R4: With `cpol` = 1 the idle level is high, and a rising strobe marks a return from the active low level. With `cpol` = 0 the idle level is low.
- R5: `rise_stb` is high for exactly the first cycle in which `sck` is newly high, and `fall_stb` for the first cycle in which it is newly low. The two strobes are never high together, and neither is high two cycles in a row.
- R6: A step above 1024 (the 14-bit `freq_word` is unsigned) acts as 1024, so `sck` toggles on every reference cycle.
- R7: A step of zero holds the accumulator, so no strobes are produced and `sck` does not change.
- R8: When `restart_en` is high, the first cycle in which `run` is seen high after being low loads the accumulator with zero. The first rising strobe then follows after ceil(1024/W) further steps, whatever phase came before.
- R9: When `restart_en` is low, a transfer start keeps the accumulator residue from the previous transfer.
- R10: When `run` is low and the raw phase is at its active half, the accumulator keeps stepping until `sck` returns to idle. Once it is idle with `run` low, no further strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_word | input | 14 | Step added per reference cycle, as a fraction of 2048 |
| restart_en | input | 1 | Clear the accumulator at each transfer start |
| cpol | input | 1 | Idle level of `sck` (1 = idle high) |
| gate_en | input | 1 | Global enable for all clock activity |
| run | input | 1 | Transfer active, driven by the shift engine |
| sck | output | 1 | Serial clock |
| rise_stb | output | 1 | One-cycle strobe on a rising `sck` edge |
| fall_stb | output | 1 | One-cycle strobe on a falling `sck` edge |

## Verification
The clock is driven with several steps: a power of two (256), a value that does not divide 2048 evenly (100), the clamped maximum (an over-range word) and zero. Together these separate correct wrap arithmetic from a plain divider and from a missing or misplaced clamp. The same stepping is repeated with inverted polarity, which shows whether the strobes follow the pin level or the raw phase. Stop requests land part-way through a half period. Back-to-back transfers run with and without restart, and the gate is dropped while the clock is running. These cases tell apart a clean park from a clipped pulse, and a cleared phase from a retained residue. A behavioural model in the bench is compared with all three outputs on every cycle. Directed counts of strobes and first-edge delays are checked on top of that.

// File: rtl/spi_fclk_pkg.sv
package spi_fclk_pkg;

   // action the phase accumulator takes on the coming edge
   typedef enum logic [1:0] {
      ACC_HOLD  = 2'd0,
      ACC_CLEAR = 2'd1,
      ACC_STEP  = 2'd2
   } acc_op_e;

endpackage

// File: rtl/fclk_word_clamp.sv
module fclk_word_clamp #(
   parameter int WORD_W   = 14,
   parameter int ACC_W    = 11,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic [WORD_W-1:0] word_in,
   output logic [ACC_W-1:0]  step_out
);
   localparam int HALF = 1 << (ACC_W - 1);
   localparam logic [WORD_W-1:0] HALF_W = WORD_W'(HALF);

   generate
      if (WORD_W < ACC_W) begin : g_bad_width
         $error("fclk_word_clamp: WORD_W must be at least ACC_W");
      end
      if (CLAMP_EN) begin : g_clamp
         // limit the step to half a turn: at most one edge per cycle
         always_comb begin
            if (word_in > HALF_W) step_out = ACC_W'(HALF);
            else                  step_out = word_in[ACC_W-1:0];
         end
      end else begin : g_wrap
         assign step_out = word_in[ACC_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/fclk_phase_acc.sv
module fclk_phase_acc
   import spi_fclk_pkg::*;
#(
   parameter int ACC_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_en,
   input  logic             run,
   input  logic             restart_en,
   input  logic [ACC_W-1:0] step,
   output logic             ph_cur,
   output logic             ph_nxt
);
   localparam int MSB = ACC_W - 1;

   logic [ACC_W-1:0] acc_q, acc_d;
   logic             run_q;
   logic             xfer_start;
   acc_op_e          op;

   generate
      if (ACC_W < 2) begin : g_bad_acc
         $error("fclk_phase_acc: ACC_W must be at least 2");
      end
   endgenerate

   assign xfer_start = run & ~run_q;
   assign ph_cur     = acc_q[MSB];

   always_comb begin
      if (!gate_en)                       op = ACC_CLEAR;
      else if (xfer_start && restart_en)  op = ACC_CLEAR;
      else if (run || ph_cur)             op = ACC_STEP;   // finish active half after stop
      else                                op = ACC_HOLD;
   end

   always_comb begin
      case (op)
         ACC_CLEAR: acc_d = '0;
         ACC_STEP:  acc_d = acc_q + step;
         default:   acc_d = acc_q;
      endcase
   end

   assign ph_nxt = acc_d[MSB];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         run_q <= 1'b0;
      end else begin
         acc_q <= acc_d;
         run_q <= run;
      end
   end

   // R2: disabling the gate clears the phase
   a_r2_gate_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_en |=> (acc_q == '0));

   // R7: a zero step freezes the phase
   a_r7_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && step == '0 && !(xfer_start && restart_en)) |=> $stable(acc_q));

   // R10: once parked with run low, the phase stays in the idle half
   a_r10_park: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ph_cur) |=> !ph_cur);

   // R8: restart at transfer start leaves a zero phase
   a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && restart_en && run && !run_q) |=> (acc_q == '0));
endmodule

// File: rtl/fclk_edge_out.sv
module fclk_edge_out (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_en,
   input  logic cpol,
   input  logic ph_cur,
   input  logic ph_nxt,
   output logic sck,
   output logic rise_stb,
   output logic fall_stb
);
   logic lvl_nxt, flip;

   assign sck     = cpol ^ ph_cur;
   assign lvl_nxt = cpol ^ ph_nxt;
   assign flip    = gate_en & (ph_nxt != ph_cur);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
      end else begin
         rise_stb <= flip &  lvl_nxt;
         fall_stb <= flip & ~lvl_nxt;
      end
   end

   // R5: strobes are exclusive and last a single cycle
   a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_stb && fall_stb));
   a_r5_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |=> !rise_stb);
   a_r5_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |=> !fall_stb);

   // R4, R5: strobe matches the new pin level
   a_r5_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_stb && $stable(cpol)) |-> sck);
   a_r5_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_stb && $stable(cpol)) |-> !sck);

   // R2: gate low silences the strobes and parks the pin
   a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_en |=> (!rise_stb && !fall_stb));
   a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_en && $stable(cpol)) |=> (sck == cpol));
endmodule

// File: rtl/spi_frac_clkgen.sv
module spi_frac_clkgen #(
   parameter int WORD_W   = 14,
   parameter int ACC_W    = 11,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] freq_word,
   input  logic              restart_en,
   input  logic              cpol,
   input  logic              gate_en,
   input  logic              run,
   output logic              sck,
   output logic              rise_stb,
   output logic              fall_stb
);
   localparam int HALF = 1 << (ACC_W - 1);

   logic [ACC_W-1:0] step;
   logic             ph_cur, ph_nxt;

   fclk_word_clamp #(
      .WORD_W  (WORD_W),
      .ACC_W   (ACC_W),
      .CLAMP_EN(CLAMP_EN)
   ) u_clamp (
      .word_in (freq_word),
      .step_out(step)
   );

   fclk_phase_acc #(
      .ACC_W(ACC_W)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .gate_en   (gate_en),
      .run       (run),
      .restart_en(restart_en),
      .step      (step),
      .ph_cur    (ph_cur),
      .ph_nxt    (ph_nxt)
   );

   fclk_edge_out u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .gate_en (gate_en),
      .cpol    (cpol),
      .ph_cur  (ph_cur),
      .ph_nxt  (ph_nxt),
      .sck     (sck),
      .rise_stb(rise_stb),
      .fall_stb(fall_stb)
   );

   // R6: the step reaching the accumulator never exceeds half a turn
   generate
      if (CLAMP_EN) begin : g_clamp_chk
         a_r6_clamp: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(step) <= HALF));
      end
   endgenerate
endmodule

// File: tb/spi_frac_clkgen_test.sv
module spi_frac_clkgen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] freq_word = '0;
   logic        restart_en = 1'b0;
   logic        cpol = 1'b0;
   logic        gate_en = 1'b0;
   logic        run = 1'b0;
   logic        sck, rise_stb, fall_stb;

   int    total = 0;
   int    bad = 0;
   int    cycles = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // reference model state
   int m_acc = 0;
   bit m_runq = 1'b0;
   bit m_rise = 1'b0;
   bit m_fall = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   spi_frac_clkgen uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .freq_word (freq_word),
      .restart_en(restart_en),
      .cpol      (cpol),
      .gate_en   (gate_en),
      .run       (run),
      .sck       (sck),
      .rise_stb  (rise_stb),
      .fall_stb  (fall_stb)
   );

   task automatic chk(input string req, input int act, input int exp, input string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural model: accumulator modulo 2048, active half when >= 1024
   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = 0; m_runq = 0; m_rise = 0; m_fall = 0;
      end else begin
         int  eff, nacc;
         bit  ph, nph, start;
         eff   = (int'(freq_word) > 1024) ? 1024 : int'(freq_word);
         ph    = (m_acc >= 1024);
         start = run && !m_runq;
         if (!gate_en)                  nacc = 0;
         else if (start && restart_en)  nacc = 0;
         else if (run || ph)            nacc = (m_acc + eff) % 2048;
         else                           nacc = m_acc;
         nph    = (nacc >= 1024);
         m_rise = gate_en && (nph != ph) && (nph ^ cpol);
         m_fall = gate_en && (nph != ph) && !(nph ^ cpol);
         m_acc  = nacc;
         m_runq = run;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         cycles++;
         chk(cur_req, int'(sck), int'(cpol ^ (m_acc >= 1024)), "sck vs model");
         chk(cur_req, int'(rise_stb), int'(m_rise), "rise_stb vs model");
         chk(cur_req, int'(fall_stb), int'(m_fall), "fall_stb vs model");
         if (cycles > 150000) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #3;
   endtask

   // clear the phase, start a transfer with restart, count strobes over 2048 steps
   task automatic rate_run(input string req, input int word, input int exp_edges);
      int nr, nf;
      nr = 0; nf = 0;
      gate_en = 0; run = 0;
      tick(1);
      freq_word = 14'(word); gate_en = 1; restart_en = 1; run = 1;
      @(posedge clk);   // start edge: phase loaded with zero
      @(posedge clk);
      for (int i = 0; i < 2048; i++) begin
         @(negedge clk);
         nr += int'(rise_stb);
         nf += int'(fall_stb);
      end
      chk(req, nr, exp_edges, "rising strobes in 2048 steps");
      chk(req, nf, exp_edges, "falling strobes in 2048 steps");
      #3;
   endtask

   // cycles from the start edge to the first rising strobe
   task automatic first_rise(input string req, input int exp_n);
      int n;
      n = 0;
      run = 1;
      @(posedge clk);
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         n++;
         if (rise_stb) break;
      end
      chk(req, n, exp_n, "cycles to first rising strobe");
      #3;
   endtask

   initial begin
      int nr, nf;
      // R1: reset state
      cur_req = "R1";
      repeat (3) @(negedge clk);
      chk("R1", int'(sck), 0, "sck in reset");
      chk("R1", int'(rise_stb) + int'(fall_stb), 0, "strobes in reset");
      @(posedge clk); #3;
      rst_n = 1;
      @(negedge clk);
      chk("R1", int'(sck), 0, "sck after reset");
      tick(1);

      // R3: rate for several steps
      cur_req = "R3";
      rate_run("R3", 256, 256);
      rate_run("R3", 100, 100);
      rate_run("R3", 1, 1);

      // R6: over-range words clamp to half a turn
      cur_req = "R6";
      rate_run("R6", 5000, 1024);
      rate_run("R6", 1024, 1024);

      // R4: inverted polarity
      cur_req = "R4";
      gate_en = 0; cpol = 1;
      tick(2);
      @(negedge clk);
      chk("R4", int'(sck), 1, "idle high with cpol set");
      #3;
      rate_run("R4", 200, 200);
      cpol = 0;

      // R7: zero step
      cur_req = "R7";
      gate_en = 0; run = 0;
      tick(1);
      gate_en = 1; freq_word = 0; run = 1;
      tick(1);
      nr = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         nr += int'(rise_stb) + int'(fall_stb);
         chk("R7", int'(sck), 0, "sck frozen with zero step");
      end
      chk("R7", nr, 0, "strobes with zero step");
      #3;

      // R8: restart gives the same first edge each time
      cur_req = "R8";
      run = 0; gate_en = 0;
      tick(1);
      gate_en = 1; restart_en = 1; freq_word = 300;
      first_rise("R8", 5);
      tick(7);
      run = 0;
      tick(3);
      first_rise("R8", 5);

      // R9: no restart keeps the residue (model compared every cycle)
      cur_req = "R9";
      tick(9);
      run = 0; restart_en = 0;
      tick(20);
      run = 1;
      tick(40);
      run = 0;
      tick(13);
      run = 1;
      tick(30);

      // R10: stop finishes the active half and then parks
      cur_req = "R10";
      gate_en = 0; run = 0;
      tick(1);
      gate_en = 1; freq_word = 64; restart_en = 1; run = 1;
      tick(20);   // phase 19*64 = 1216: active half
      run = 0;
      @(posedge clk);
      nr = 0; nf = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         nr += int'(rise_stb);
         nf += int'(fall_stb);
      end
      chk("R10", nr, 0, "rising strobes after stop");
      chk("R10", nf, 1, "falling strobes while finishing half");
      chk("R10", int'(sck), 0, "parked at idle");
      #3;

      // R2: gate drop while running
      cur_req = "R2";
      freq_word = 512; run = 1;
      tick(37);
      gate_en = 0;
      @(posedge clk);
      nr = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         nr += int'(rise_stb) + int'(fall_stb);
         chk("R2", int'(sck), 0, "idle with gate low");
      end
      chk("R2", nr, 0, "strobes with gate low");
      #3;

      // R5 covered by the per-cycle model across a fast toggling run
      cur_req = "R5";
      gate_en = 1; freq_word = 700; run = 1;
      tick(200);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule